// File: doc/BRIEF.md
# Half-Rate Double-Word Combiner with Comma Alignment

This block sits right after a link receiver. The receiver delivers two decoded bytes (16 bits) per receive clock, along with a flag that marks a comma half. The block joins each pair of consecutive halves into one 32-bit double word for the frame-processing logic. It also produces a half-rate phase signal that can serve as a clock or clock enable for that logic.

The comma sets the pairing phase. A half that carries a comma always becomes the upper half of a new double word, and the comma flag comes out on the same cycle as that word. Until the first comma arrives the block has no valid word boundary, so it emits nothing. A comma that arrives while a first half is still waiting for its partner forces a resync: the waiting half is dropped and the comma half starts a fresh word.

Top module: `hrate_word_combiner`

## Requirements
- R1: While `rst_n` is sampled low on a rising `clk` edge, the next state has `dw_valid`=0, `dw_comma`=0, `half_clk`=0 and `dw_data`=0.
- R2: After reset and before any half with `rx_comma`=1 has been sampled, `dw_valid` stays 0 whatever `rx_data` carries. A reset in mid-stream returns the block to this unlocked state.
- R3: A double word places the first half received in bits [31:16] and the second half in bits [15:0]. `dw_valid` rises one clock after the edge that samples the second half.
- R4: `dw_comma` is 1 only in a cycle where `dw_valid` is 1, and only when the upper half of that word was sampled with `rx_comma`=1.
- R5: Once locked, comma-free halves pair in the order they arrive. `dw_valid` is high for exactly one clock per word and is never high in two consecutive clocks.
- R6: A half sampled with `rx_comma`=1 always starts a new word. Any first half still waiting for its partner is discarded, and `dw_valid` is 0 on the next clock.
- R7: `half_clk` is 1 exactly while a first half is held and waiting for its partner. In a locked stream it toggles on every clock, which gives half the receive frequency.
- R8: `dw_data` keeps its value in every cycle where `dw_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 16 | Decoded byte pair from the receiver |
| rx_comma | input | 1 | Comma detected in this byte pair |
| dw_data | output | 32 | Assembled double word |
| dw_comma | output | 1 | Word began with a comma half |
| dw_valid | output | 1 | One-clock strobe per completed word |
| half_clk | output | 1 | Half-rate phase; high while a first half is held |

## Verification
Every result is due exactly one clock after the edge that samples the stimulus causing it. `half_clk` follows the half sampled on that edge. `dw_valid`, `dw_data` and `dw_comma` follow the second half of a pair. The bench drives each half on the falling edge and updates its expected model right after the next rising edge. It compares all outputs on the following falling edge, so every comparison lands in the one cycle where the result is due. Directed cases cover the unlocked stream, a comma on a pending half, back-to-back commas and a mid-stream reset. A seeded random stream with scattered commas covers the rest.

// File: rtl/hwc_pkg.sv
// Shared types for the half-rate word combiner.
// Assumes: nothing beyond a single receive clock domain.
package hwc_pkg;
    // Which half of a double word the next sampled input fills.
    typedef enum logic {
        SLOT_UPPER = 1'b0,
        SLOT_LOWER = 1'b1
    } slot_e;
endpackage

// File: rtl/hwc_slot_ctrl.sv
// Tracks comma lock and which half of the double word comes next.
// Assumes: a comma always marks the upper half of a word (frames are
// double-word aligned), so a comma re-centres the pairing phase.
module hwc_slot_ctrl
    import hwc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_comma,
    output logic  locked,
    output slot_e slot,
    output logic  take_upper,
    output logic  take_lower
);
    // Lock on the first comma, then alternate; a comma forces the lower slot next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            slot   <= SLOT_UPPER;
        end else if (in_comma) begin
            locked <= 1'b1;
            slot   <= SLOT_LOWER;
        end else if (locked) begin
            slot   <= (slot == SLOT_UPPER) ? SLOT_LOWER : SLOT_UPPER;
        end
    end

    // Decode whether this input opens or closes a word.
    always_comb begin
        take_upper = in_comma || (locked && slot == SLOT_UPPER);
        take_lower = !in_comma && locked && (slot == SLOT_LOWER);
    end

    // R2
    // lower_needs_lock_chk
    lower_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_LOWER) |-> locked);

    // R7
    // lower_then_upper_chk
    lower_then_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_LOWER && !in_comma) |=> (slot == SLOT_UPPER));
endmodule

// File: rtl/hwc_half_hold.sv
// Holds the upper half of a word and its comma mark until the lower half arrives.
// Assumes: load is only raised when the input is an upper half.
module hwc_half_hold #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] in_data,
    input  logic              in_comma,
    output logic [HALF_W-1:0] held_data,
    output logic              held_comma
);
    // Capture the opening half of a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_data  <= '0;
            held_comma <= 1'b0;
        end else if (load) begin
            held_data  <= in_data;
            held_comma <= in_comma;
        end
    end
endmodule

// File: rtl/hwc_word_out.sv
// Output register: joins the held upper half with the lower half and strobes valid.
// Assumes: complete is high for one cycle per word.
module hwc_word_out #(
    parameter int HALF_W = 16,
    localparam int DW_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic [HALF_W-1:0] upper,
    input  logic              upper_comma,
    input  logic [HALF_W-1:0] lower,
    output logic [DW_W-1:0]   dw_data,
    output logic              dw_comma,
    output logic              dw_valid
);
    // Register the finished word; data holds between words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw_data  <= '0;
            dw_comma <= 1'b0;
            dw_valid <= 1'b0;
        end else begin
            dw_valid <= complete;
            dw_comma <= complete && upper_comma;
            if (complete) dw_data <= {upper, lower};
        end
    end

    // R5
    // single_strobe_chk
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dw_valid |=> !dw_valid);

    // R8
    // data_hold_chk
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dw_valid |-> $stable(dw_data));

    // R4
    // comma_with_word_chk
    comma_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dw_comma |-> dw_valid);
endmodule

// File: rtl/hrate_word_combiner.sv
// Top: pairs 16-bit receive halves into 32-bit double words, aligned on commas,
// with a half-rate phase output for downstream frame logic.
// Assumes: receiver in single two-bytes-per-clock mode, bytes already decoded.
module hrate_word_combiner
    import hwc_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int DW_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] rx_data,
    input  logic              rx_comma,
    output logic [DW_W-1:0]   dw_data,
    output logic              dw_comma,
    output logic              dw_valid,
    output logic              half_clk
);
    logic              locked;
    slot_e             slot;
    logic              take_upper;
    logic              take_lower;
    logic [HALF_W-1:0] held_data;
    logic              held_comma;

    hwc_slot_ctrl u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_comma   (rx_comma),
        .locked     (locked),
        .slot       (slot),
        .take_upper (take_upper),
        .take_lower (take_lower)
    );

    hwc_half_hold #(.HALF_W(HALF_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take_upper),
        .in_data    (rx_data),
        .in_comma   (rx_comma),
        .held_data  (held_data),
        .held_comma (held_comma)
    );

    hwc_word_out #(.HALF_W(HALF_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .complete    (take_lower),
        .upper       (held_data),
        .upper_comma (held_comma),
        .lower       (rx_data),
        .dw_data     (dw_data),
        .dw_comma    (dw_comma),
        .dw_valid    (dw_valid)
    );

    // Half-rate phase: high while an upper half waits for its partner.
    always_comb half_clk = (slot == SLOT_LOWER);

    // R6
    // comma_restart_chk
    comma_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_comma |=> (half_clk && !dw_valid));

    // R3
    // word_after_pending_chk
    word_after_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dw_valid |-> $past(half_clk));

    // R2
    // no_word_unlocked_chk
    no_word_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dw_valid |-> $past(locked));
endmodule

// File: tb/sim_hrate_word_combiner.sv
`timescale 1ns/1ps
module sim_hrate_word_combiner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_comma = 1'b0;
    logic [31:0] dw_data;
    logic        dw_comma;
    logic        dw_valid;
    logic        half_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expected model state
    bit          m_lock, m_phase, m_hc, m_valid, m_comma;
    logic [15:0] m_hold;
    logic [31:0] m_data;

    always #4 clk = ~clk;

    hrate_word_combiner u0 (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_comma(rx_comma),
        .dw_data(dw_data), .dw_comma(dw_comma), .dw_valid(dw_valid), .half_clk(half_clk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_lock = 0; m_phase = 0; m_hc = 0; m_valid = 0; m_comma = 0;
        m_hold = '0; m_data = '0;
    endtask

    // Requirement-level model of one sampled half.
    task automatic model_step(input logic [15:0] d, input bit c);
        m_valid = 0;
        m_comma = 0;
        if (c) begin
            m_hold = d; m_hc = 1; m_phase = 1; m_lock = 1;
        end else if (m_lock && !m_phase) begin
            m_hold = d; m_hc = 0; m_phase = 1;
        end else if (m_lock && m_phase) begin
            m_data = {m_hold, d}; m_comma = m_hc; m_valid = 1; m_phase = 0;
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " R5 dw_valid"}, 32'(dw_valid), 32'(m_valid));
        chk({tag, " R7 half_clk"}, 32'(half_clk), 32'(m_phase));
        chk({tag, " R3/R8 dw_data"}, dw_data, m_data);
        chk({tag, " R4 dw_comma"}, 32'(dw_comma), 32'(m_comma));
    endtask

    // Drive on falling edge, model after rising edge, compare on next falling edge.
    task automatic step(input logic [15:0] d, input bit c, input string tag);
        rx_data  = d;
        rx_comma = c;
        @(posedge clk);
        model_step(d, c);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 0;
        rx_comma = 0;
        @(posedge clk);
        @(posedge clk);
        model_clear();
        @(negedge clk);
        chk("R1 valid", 32'(dw_valid), 0);
        chk("R1 comma", 32'(dw_comma), 0);
        chk("R1 half_clk", 32'(half_clk), 0);
        chk("R1 data", dw_data, 0);
        rst_n = 1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        model_clear();
        @(negedge clk);
        do_reset();

        // R2: no words before lock
        for (int i = 0; i < 6; i++) step(16'hA000 + 16'(i), 0, "R2 unlocked");

        // R3/R4: comma word then comma-free word
        step(16'hBC50, 1, "R3 comma upper");
        step(16'h1234, 0, "R3 lower");
        step(16'h5678, 0, "R5 upper");
        step(16'h9ABC, 0, "R5 lower");

        // R6: comma on a pending upper half drops it
        step(16'h1111, 0, "R6 pending");
        step(16'hBC95, 1, "R6 resync comma");
        step(16'h2222, 0, "R6 lower");

        // R6: back-to-back commas
        step(16'hBCB5, 1, "R6 comma a");
        step(16'hBCC5, 1, "R6 comma b");
        step(16'h3333, 0, "R6 lower b");

        // R8: idle gap while a word is incomplete keeps data
        step(16'h4444, 0, "R8 upper");
        step(16'h5555, 0, "R8 lower");

        // R2: mid-stream reset returns to unlocked
        step(16'h6666, 0, "R2 pre-reset");
        do_reset();
        for (int i = 0; i < 4; i++) step(16'hC000 + 16'(i), 0, "R2 relock wait");
        step(16'hBCDA, 1, "R3 relock");
        step(16'h7777, 0, "R3 relock lower");

        // random stream with scattered commas
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            bit c;
            d = 16'($urandom);
            c = ($urandom % 16) == 0;
            step(d, c, "rand");
        end

        finish_up();
    end
endmodule